// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss for a 32-bit virtual address. A miss request carries the virtual page number of the stalled access. The block latches that page number together with the current table base register. It then makes two physical memory reads on a request/acknowledge port, which does not pass through translation. The first read returns a directory entry. The second read, made only when that directory entry is valid, returns a leaf entry that holds the physical page number.

Both levels are tables of 1024 four-byte entries. The top ten bits of the virtual address select the directory slot. The next ten bits select the leaf slot. The twelve-bit page offset never enters the walker.

When the leaf entry is valid, the walker pulses a one-cycle refill that carries the virtual and physical page numbers. The translation buffer writes this pair and then lets the stalled access restart. An invalid entry at either level ends the walk with a one-cycle fault pulse and no refill. Only one walk runs at a time.

Top module: `ptw_walker`

## Requirements
- R1: While reset (rst_n low, sampled at a rising edge) is active, and on the cycle after it, miss_ready is 1. In the same window mem_req, refill_valid and fault_valid are 0, and a miss request that is held during reset does not start a walk.
- R2: The first read of a walk goes to base + VPN[19:10]*4. The base is the value of base_addr in the cycle the miss was accepted. The addition is a full 32-bit add, so the base need not be aligned.
- R3: mem_req stays high and mem_addr stays unchanged from the cycle a read is raised until the cycle mem_ack is seen. The read is dropped in the cycle after the acknowledge.
- R4: If bit 0 of the directory entry is 1, the second read goes to {entry[31:12], VPN[9:0], 2'b00}.
- R5: If bit 0 of the directory entry is 0, no second read is made. fault_valid pulses for one cycle in the cycle after the acknowledge.
- R6: If bit 0 of the leaf entry is 1, refill_valid pulses for one cycle in the cycle after the acknowledge. During that pulse refill_vpn equals the accepted VPN and refill_ppn equals leaf entry bits [31:12].
- R7: If bit 0 of the leaf entry is 0, fault_valid pulses for one cycle and refill_valid stays 0.
- R8: A miss is accepted only when miss_ready and miss_valid are both 1. miss_ready is 0 from the cycle after acceptance until the walk has finished. A miss_valid or miss_vpn change while the walker is busy does not alter that walk.
- R9: Each walk ends with exactly one of refill_valid or fault_valid. miss_ready returns to 1 in the cycle after that pulse.
- R10: A change of base_addr after a miss has been accepted has no effect on the read addresses of that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_addr | input | 32 | Physical address of the current directory table |
| miss_valid | input | 1 | A translation miss is waiting |
| miss_vpn | input | 20 | Virtual page number (VA[31:12]) of the missing access |
| miss_ready | output | 1 | Walker idle; a miss is taken this cycle if valid |
| mem_req | output | 1 | Physical read request |
| mem_addr | output | 32 | Physical read byte address |
| mem_ack | input | 1 | Read data valid; completes the current request |
| mem_rdata | input | 32 | Table entry returned with mem_ack |
| refill_valid | output | 1 | One-cycle refill strobe; the stalled access may restart |
| refill_vpn | output | 20 | Virtual page number of the refill |
| refill_ppn | output | 20 | Physical page number from the leaf entry |
| fault_valid | output | 1 | One-cycle strobe: the walk found an invalid entry |

## Verification
A new miss request can arrive in the same cycle as the completion strobe of the walk in progress. In that cycle the walker must still refuse the request. To provoke this, the bench holds miss_valid high, with a second page number, across an entire walk. The bench then checks three things. The completing refill carries the first page number. miss_ready is still low during the strobe. The very next directory read is computed from the second page number, taken only after miss_ready has come back.

// File: rtl/ptw_pkg.sv
// Package: shared state encoding and entry-format constants for the walker.
// Assumes every table entry keeps its valid flag in bit 0.
package ptw_pkg;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_DIR,
        WS_LEAF,
        WS_DONE,
        WS_FAULT
    } walk_state_e;

    localparam int unsigned PTE_VALID_BIT = 0;

endpackage

// File: rtl/ptw_ctrl.sv
// Module: walk sequencer. It steps idle -> directory read -> leaf read -> done/fault.
// Assumes mem_ack is only meaningful while a read is requested.
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        miss_valid,
    input  logic        mem_ack,
    input  logic        entry_valid,
    output walk_state_e state,
    output logic        accept,
    output logic        dir_take,
    output logic        leaf_take
);

    walk_state_e state_nxt;

    // Decode the strobes that load the context registers.
    always_comb begin
        accept    = (state == WS_IDLE) && miss_valid;
        dir_take  = (state == WS_DIR)  && mem_ack && entry_valid;
        leaf_take = (state == WS_LEAF) && mem_ack && entry_valid;
    end

    // Next-state selection for the fixed two-read walk.
    always_comb begin
        state_nxt = state;
        unique case (state)
            WS_IDLE:  if (miss_valid) state_nxt = WS_DIR;
            WS_DIR:   if (mem_ack) state_nxt = entry_valid ? WS_LEAF : WS_FAULT;
            WS_LEAF:  if (mem_ack) state_nxt = entry_valid ? WS_DONE : WS_FAULT;
            WS_DONE:  state_nxt = WS_IDLE;
            WS_FAULT: state_nxt = WS_IDLE;
            default:  state_nxt = WS_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= WS_IDLE;
        else        state <= state_nxt;
    end

    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (state == WS_DIR));

endmodule

// File: rtl/ptw_ctx.sv
// Module: walk context. It holds the page number, the base, the table frame and the result frame.
// Assumes the load strobes are mutually exclusive (they come from one state machine).
module ptw_ctx #(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned PA_W  = 32,
    parameter int unsigned PTE_W = 32,
    parameter int unsigned OFF_W = 12,
    localparam int unsigned VPN_W = VA_W - OFF_W,
    localparam int unsigned PPN_W = PA_W - OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             dir_take,
    input  logic             leaf_take,
    input  logic [VPN_W-1:0] miss_vpn,
    input  logic [PA_W-1:0]  base_addr,
    input  logic [PTE_W-1:0] entry,
    output logic [VPN_W-1:0] vpn_q,
    output logic [PA_W-1:0]  base_q,
    output logic [PPN_W-1:0] tbl_q,
    output logic [PPN_W-1:0] ppn_q
);

    // Capture the request fields once; they are frozen for the whole walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q  <= '0;
            base_q <= '0;
        end else if (accept) begin
            vpn_q  <= miss_vpn;
            base_q <= base_addr;
        end
    end

    // Capture the frame fields of the directory and leaf entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
            ppn_q <= '0;
        end else begin
            if (dir_take)  tbl_q <= entry[OFF_W +: PPN_W];
            if (leaf_take) ppn_q <= entry[OFF_W +: PPN_W];
        end
    end

    // R10
    base_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(base_q));

endmodule

// File: rtl/ptw_addr_gen.sv
// Module: read-address former. It forms the directory and leaf slot addresses.
// Assumes IDX_W plus the entry shift equals OFF_W, so a leaf table fills one page.
// ALIGNED_BASE=1 replaces the base adder by concatenation when the base is page aligned.
module ptw_addr_gen #(
    parameter int unsigned VA_W         = 32,
    parameter int unsigned PA_W         = 32,
    parameter int unsigned PTE_W        = 32,
    parameter int unsigned OFF_W        = 12,
    parameter int unsigned IDX_W        = 10,
    parameter bit          ALIGNED_BASE = 1'b0,
    localparam int unsigned VPN_W  = VA_W - OFF_W,
    localparam int unsigned PPN_W  = PA_W - OFF_W,
    localparam int unsigned ENT_SH = $clog2(PTE_W / 8)
) (
    input  logic [VPN_W-1:0] vpn_q,
    input  logic [PA_W-1:0]  base_q,
    input  logic [PPN_W-1:0] tbl_q,
    input  logic             leaf_sel,
    output logic [PA_W-1:0]  addr
);

    logic [IDX_W-1:0] dir_idx;
    logic [IDX_W-1:0] leaf_idx;
    logic [PA_W-1:0]  dir_addr;
    logic [PA_W-1:0]  leaf_addr;

    // Split the page number into the two table indices.
    always_comb begin
        dir_idx  = vpn_q[VPN_W-1 -: IDX_W];
        leaf_idx = vpn_q[IDX_W-1:0];
    end

    generate
        if (ALIGNED_BASE) begin : g_cat
            // Page-aligned base: slot offset drops into the low bits.
            always_comb dir_addr = {base_q[PA_W-1:OFF_W], dir_idx, {ENT_SH{1'b0}}};
        end else begin : g_add
            // General base: full-width add of the scaled index.
            always_comb dir_addr = base_q
                + {{(PA_W-IDX_W-ENT_SH){1'b0}}, dir_idx, {ENT_SH{1'b0}}};
        end
    endgenerate

    // Leaf table frames are page aligned, so the slot is a plain concatenation.
    always_comb begin
        leaf_addr = {tbl_q, leaf_idx, {ENT_SH{1'b0}}};
        addr      = leaf_sel ? leaf_addr : dir_addr;
    end

endmodule

// File: rtl/ptw_walker.sv
// Module: top of the two-level page table walker.
// It accepts one miss at a time and makes two untranslated reads.
// It ends with a refill strobe or a fault strobe.
// Assumes the memory keeps mem_ack low while no read is requested.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int unsigned VA_W         = 32,
    parameter int unsigned PA_W         = 32,
    parameter int unsigned PTE_W        = 32,
    parameter int unsigned OFF_W        = 12,
    parameter int unsigned IDX_W        = 10,
    parameter bit          ALIGNED_BASE = 1'b0,
    localparam int unsigned VPN_W = VA_W - OFF_W,
    localparam int unsigned PPN_W = PA_W - OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PA_W-1:0]  base_addr,
    input  logic             miss_valid,
    input  logic [VPN_W-1:0] miss_vpn,
    output logic             miss_ready,
    output logic             mem_req,
    output logic [PA_W-1:0]  mem_addr,
    input  logic             mem_ack,
    input  logic [PTE_W-1:0] mem_rdata,
    output logic             refill_valid,
    output logic [VPN_W-1:0] refill_vpn,
    output logic [PPN_W-1:0] refill_ppn,
    output logic             fault_valid
);

    walk_state_e      state;
    logic             accept;
    logic             dir_take;
    logic             leaf_take;
    logic             entry_valid;
    logic [VPN_W-1:0] vpn_q;
    logic [PA_W-1:0]  base_q;
    logic [PPN_W-1:0] tbl_q;
    logic [PPN_W-1:0] ppn_q;

    // Valid flag of whichever entry is being returned.
    always_comb entry_valid = mem_rdata[PTE_VALID_BIT];

    ptw_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .miss_valid  (miss_valid),
        .mem_ack     (mem_ack),
        .entry_valid (entry_valid),
        .state       (state),
        .accept      (accept),
        .dir_take    (dir_take),
        .leaf_take   (leaf_take)
    );

    ptw_ctx #(
        .VA_W (VA_W), .PA_W (PA_W), .PTE_W (PTE_W), .OFF_W (OFF_W)
    ) u_ctx (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .dir_take  (dir_take),
        .leaf_take (leaf_take),
        .miss_vpn  (miss_vpn),
        .base_addr (base_addr),
        .entry     (mem_rdata),
        .vpn_q     (vpn_q),
        .base_q    (base_q),
        .tbl_q     (tbl_q),
        .ppn_q     (ppn_q)
    );

    ptw_addr_gen #(
        .VA_W (VA_W), .PA_W (PA_W), .PTE_W (PTE_W), .OFF_W (OFF_W),
        .IDX_W (IDX_W), .ALIGNED_BASE (ALIGNED_BASE)
    ) u_addr (
        .vpn_q    (vpn_q),
        .base_q   (base_q),
        .tbl_q    (tbl_q),
        .leaf_sel (state == WS_LEAF),
        .addr     (mem_addr)
    );

    // Drive the handshake and result outputs from the walk state.
    always_comb begin
        miss_ready   = (state == WS_IDLE);
        mem_req      = (state == WS_DIR) || (state == WS_LEAF);
        refill_valid = (state == WS_DONE);
        fault_valid  = (state == WS_FAULT);
        refill_vpn   = vpn_q;
        refill_ppn   = ppn_q;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (miss_ready && !mem_req && !refill_valid && !fault_valid));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R4
    leaf_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WS_DIR && mem_ack && mem_rdata[PTE_VALID_BIT])
        |=> (mem_req && mem_addr[PA_W-1:OFF_W] == $past(mem_rdata[OFF_W +: PPN_W])));

    // R5 and R7
    bad_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_rdata[PTE_VALID_BIT])
        |=> (fault_valid && !refill_valid && !mem_req));

    // R6
    refill_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WS_LEAF && mem_ack && mem_rdata[PTE_VALID_BIT])
        |=> (refill_valid && refill_ppn == $past(mem_rdata[OFF_W +: PPN_W])));

    // R8
    accept_vpn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_ready && miss_valid)
        |=> (!miss_ready && mem_req && refill_vpn == $past(miss_vpn)));

    // R9
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_valid || fault_valid) |=> (miss_ready && !refill_valid && !fault_valid));

endmodule

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_addr = '0;
    logic        miss_valid = 1'b0;
    logic [19:0] miss_vpn = '0;
    logic        miss_ready;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        refill_valid;
    logic [19:0] refill_vpn;
    logic [19:0] refill_ppn;
    logic        fault_valid;

    always #4 clk = ~clk;

    ptw_walker dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .base_addr    (base_addr),
        .miss_valid   (miss_valid),
        .miss_vpn     (miss_vpn),
        .miss_ready   (miss_ready),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .refill_valid (refill_valid),
        .refill_vpn   (refill_vpn),
        .refill_ppn   (refill_ppn),
        .fault_valid  (fault_valid)
    );

    int n_chk = 0;
    int n_fail = 0;
    int n_req = 0;
    int stab_err = 0;
    int lat = 0;
    logic [31:0] tab_addr [4];
    logic [31:0] tab_data [4];
    logic [31:0] req_log  [8];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] lookup(input logic [31:0] a);
        for (int i = 0; i < 4; i++) if (tab_addr[i] == a) return tab_data[i];
        return 32'h0;
    endfunction

    function automatic logic [31:0] dir_of(input logic [31:0] base, input logic [19:0] vpn);
        return base + {20'h0, vpn[19:10], 2'b00};
    endfunction

    function automatic logic [31:0] leaf_of(input logic [31:0] dent, input logic [19:0] vpn);
        return {dent[31:12], vpn[9:0], 2'b00};
    endfunction

    // Memory model: answers each read after lat cycles and logs the address.
    initial begin
        int wcnt;
        logic [31:0] first;
        wcnt = 0;
        first = '0;
        forever begin
            @(negedge clk);
            if (!rst_n || mem_ack) begin
                mem_ack = 1'b0;
                wcnt = 0;
            end else if (mem_req) begin
                if (wcnt == 0) begin
                    first = mem_addr;
                    if (n_req < 8) req_log[n_req] = mem_addr;
                    n_req++;
                end else if (mem_addr != first) begin
                    stab_err++;
                end
                if (wcnt >= lat) begin
                    mem_ack = 1'b1;
                    mem_rdata = lookup(mem_addr);
                end else begin
                    wcnt++;
                end
            end
        end
    end

    task automatic clear_tab();
        for (int i = 0; i < 4; i++) begin
            tab_addr[i] = 32'hFFFF_FFF0 - i;
            tab_data[i] = 32'h0;
        end
        n_req = 0;
        stab_err = 0;
    endtask

    // kind: 0 timeout, 1 refill, 2 fault, 3 both
    task automatic wait_done(output int kind, output logic [19:0] vpn, output logic [19:0] ppn);
        kind = 0;
        vpn = '0;
        ppn = '0;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            if (refill_valid || fault_valid) begin
                kind = (refill_valid ? 1 : 0) + (fault_valid ? 2 : 0);
                vpn = refill_vpn;
                ppn = refill_ppn;
                break;
            end
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        miss_valid = 1'b1;
        miss_vpn = 20'h12345;
        repeat (3) @(negedge clk);
        check(miss_ready && !mem_req && !refill_valid && !fault_valid, "R1 reset outputs",
              {28'h0, miss_ready, mem_req, refill_valid, fault_valid}, 32'h8);
        miss_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(miss_ready && !mem_req, "R1 idle after reset", {30'h0, miss_ready, mem_req}, 32'h2);
        check(n_req == 0, "R1 no read during reset", n_req, 0);
    endtask

    task automatic run_walk(input logic [19:0] vpn, input logic [31:0] base, input logic [31:0] dent,
                            input logic [31:0] lent, input int l, input bit scramble, input string tag);
        int kind;
        logic [19:0] gv, gp;
        bit dir_ok, leaf_ok;
        clear_tab();
        lat = l;
        dir_ok = dent[0];
        leaf_ok = lent[0];
        tab_addr[0] = dir_of(base, vpn);
        tab_data[0] = dent;
        tab_addr[1] = leaf_of(dent, vpn);
        tab_data[1] = lent;
        check(miss_ready, {tag, " R9 ready before miss"}, miss_ready, 1);
        miss_vpn = vpn;
        base_addr = base;
        miss_valid = 1'b1;
        @(negedge clk);
        miss_valid = 1'b0;
        check(!miss_ready && mem_req, {tag, " R8 busy after accept"}, {30'h0, miss_ready, mem_req}, 32'h1);
        miss_vpn = ~vpn;
        if (scramble) base_addr = ~base;
        wait_done(kind, gv, gp);
        check(req_log[0] == tab_addr[0], {tag, " R2 directory address"}, req_log[0], tab_addr[0]);
        check(stab_err == 0, {tag, " R3 address held until ack"}, stab_err, 0);
        if (!dir_ok) begin
            check(kind == 2, {tag, " R5 directory fault"}, kind, 2);
            check(n_req == 1, {tag, " R5 no second read"}, n_req, 1);
        end else begin
            check(n_req == 2, {tag, " R4 two reads"}, n_req, 2);
            check(req_log[1] == tab_addr[1], {tag, " R4 leaf address"}, req_log[1], tab_addr[1]);
            if (leaf_ok) begin
                check(kind == 1, {tag, " R6 refill strobe"}, kind, 1);
                check(gv == vpn, {tag, " R6 refill vpn"}, {12'h0, gv}, {12'h0, vpn});
                check(gp == lent[31:12], {tag, " R6 refill ppn"}, {12'h0, gp}, {12'h0, lent[31:12]});
            end else begin
                check(kind == 2, {tag, " R7 leaf fault"}, kind, 2);
            end
        end
        if (scramble) check(req_log[0] == dir_of(base, vpn), {tag, " R10 base change ignored"},
                            req_log[0], dir_of(base, vpn));
        @(negedge clk);
        check(miss_ready && !refill_valid && !fault_valid, {tag, " R9 single strobe then ready"},
              {29'h0, miss_ready, refill_valid, fault_valid}, 32'h4);
        base_addr = base;
    endtask

    task automatic test_overlap();
        int kind;
        logic [19:0] gv, gp;
        logic [19:0] va_a, va_b;
        logic [31:0] base;
        va_a = 20'h0ACE1;
        va_b = 20'h3F00F;
        base = 32'h0040_0000;
        clear_tab();
        lat = 1;
        tab_addr[0] = dir_of(base, va_a);      tab_data[0] = 32'h0050_0001;
        tab_addr[1] = leaf_of(32'h0050_0001, va_a); tab_data[1] = 32'h1111_1001;
        tab_addr[2] = dir_of(base, va_b);      tab_data[2] = 32'h0060_0001;
        tab_addr[3] = leaf_of(32'h0060_0001, va_b); tab_data[3] = 32'h2222_2001;
        base_addr = base;
        miss_vpn = va_a;
        miss_valid = 1'b1;
        @(negedge clk);
        miss_vpn = va_b;
        wait_done(kind, gv, gp);
        check(kind == 1 && gv == va_a, "R8 held miss ignored while busy", {12'h0, gv}, {12'h0, va_a});
        check(!miss_ready, "R8 not ready during refill strobe", miss_ready, 0);
        check(gp == 20'h11111, "R6 first refill ppn", {12'h0, gp}, 32'h11111);
        @(negedge clk);
        check(miss_ready, "R9 ready after strobe", miss_ready, 1);
        @(negedge clk);
        miss_valid = 1'b0;
        check(!miss_ready && mem_req, "R8 second miss accepted", {30'h0, miss_ready, mem_req}, 32'h1);
        wait_done(kind, gv, gp);
        check(n_req == 4 && req_log[2] == tab_addr[2], "R2 second walk directory address",
              req_log[2], tab_addr[2]);
        check(kind == 1 && gv == va_b && gp == 20'h22222, "R6 second refill",
              {12'h0, gp}, 32'h22222);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R9 watchdog expired: actual hung expected completion");
        finish_run();
    end

    initial begin
        test_reset();
        run_walk(20'h12345, 32'h0010_0000, 32'h0020_0001, 32'hABCD_E003, 0, 1'b0, "basic");
        run_walk(20'hFFC03, 32'h0123_4FFC, 32'h0077_7001, 32'h0BEE_F001, 3, 1'b1, "slow");
        run_walk(20'h00400, 32'h0010_0000, 32'h0030_0000, 32'h0000_0001, 2, 1'b0, "dirbad");
        run_walk(20'h7A5C3, 32'h0008_0000, 32'h0090_0001, 32'h5555_5000, 1, 1'b0, "leafbad");
        test_overlap();
        finish_run();
    end

endmodule